// File: doc/BRIEF.md
# Partial Reconfiguration Host Sequencer

This block sits on the host side of a partial-reconfiguration link. It runs one session at a time against a configuration controller, using a four-signal handshake. The host raises a request and waits for the controller's ready. It then forwards bitstream words from a valid/ready source at up to one word per clock, and idles the data bus. Finally it waits for the controller to report completion or failure and withdraws the request. The controller answers asynchronously, so its ready, done, PR-error and CRC-error lines are synchronized with two flops each before the state machine looks at them.

A session can fail in three ways: the controller reports an error, the controller stays silent for longer than a programmable limit, or the local side aborts. Each failure gives a one-cycle fail pulse with a two-bit cause. A good session gives a one-cycle success pulse. After any withdrawal, the sequencer holds the request low for a minimum gap before it accepts the next start. A busy level covers the whole session, including the clean-up phases.

Top module: `pr_host_seq`

## Requirements
- R1: After reset, `ctl_req_o`, `busy_o`, `ok_o`, `fail_o`, `ctl_data_vld_o` and `src_ready_o` are 0 and `ctl_data_o` is all zeros.
- R2: A level on `start_i` in idle raises `ctl_req_o` with `ctl_data_o` at zero. `src_ready_o` stays 0 until the synchronized controller ready has been seen.
- R3: Every word accepted from the source (`src_valid_i` and `src_ready_o` high at a clock edge) appears on `ctl_data_o` with `ctl_data_vld_o` high one cycle later, in acceptance order. A cycle with `src_valid_i` low yields `ctl_data_vld_o` low. The word with `src_last_i` high ends streaming.
- R4: Whenever `ctl_data_vld_o` is 0, `ctl_data_o` is all zeros.
- R5: When done is seen after the last word, `ok_o` pulses for one cycle and `ctl_req_o` drops in that same cycle. `busy_o` falls once done has deasserted.
- R6: A PR error during a session pulses `fail_o` with cause 2'b10. `ctl_req_o` stays high until ready deasserts, then drops. The sequencer returns to idle once the error lines clear.
- R7: A CRC error pulses `fail_o` with cause 2'b01 and is handled like R6. When CRC error and PR error arrive together, cause 2'b01 wins.
- R8: If ready (while requesting) or done (after the last word) fails to arrive within `timeout_lim_i` cycles (0 disables the limit), `fail_o` pulses with cause 2'b11 and `ctl_req_o` drops.
- R9: `abort_i` during a session pulses `fail_o` with cause 2'b00 and drops `ctl_req_o` at once. `busy_o` stays high until ready is low.
- R10: `ctl_req_o` is low for at least `GAP` (default 10) consecutive cycles before every new rise.
- R11: An error seen in the same cycle as done wins. Only `fail_o` pulses and `ok_o` does not, and `ok_o` and `fail_o` are never high together.
- R12: `busy_o` is high from the accepted start until the session's clean-up ends. `ctl_req_o` is never high while `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Data clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request level, taken in idle once the gap has elapsed |
| abort_i | input | 1 | Abort the running session |
| timeout_lim_i | input | TW | Wait limit in cycles for ready and done; 0 disables |
| src_data_i | input | DW | Bitstream word from the source |
| src_valid_i | input | 1 | Source word valid |
| src_last_i | input | 1 | Marks the final bitstream word |
| src_ready_o | output | 1 | Sequencer accepts a source word |
| ctl_req_o | output | 1 | Session request to the controller |
| ctl_data_o | output | DW | Data bus to the controller, zero when idle |
| ctl_data_vld_o | output | 1 | Qualifier for ctl_data_o |
| ctl_ready_i | input | 1 | Controller ready, asynchronous |
| ctl_done_i | input | 1 | Controller done, asynchronous |
| ctl_err_i | input | 1 | Controller PR error, asynchronous |
| ctl_crc_err_i | input | 1 | Controller CRC error, asynchronous |
| busy_o | output | 1 | Session in progress |
| ok_o | output | 1 | One-cycle success pulse |
| fail_o | output | 1 | One-cycle failure pulse |
| fail_cause_o | output | 2 | Cause with fail_o: 00 abort, 01 CRC, 10 PR error, 11 timeout |

## Verification
Completion and failure can land in the same cycle. The bench provokes this by raising done and the PR error together after the last word, after a few idle bus cycles. The scoreboard then expects exactly one fail event with cause 2'b10 and no success event, so a stray `ok_o` pulse is a miscompare. A CRC error raised together with a PR error is judged the same way and must report cause 2'b01. Back-to-back sessions, driven by holding `start_i` high, check the minimum request-low gap.

// File: rtl/pr_seq_pkg.sv
package pr_seq_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_REQ, S_STREAM, S_FLUSH, S_DONE_WAIT, S_ERR_HOLD, S_ERR_CLR, S_WITHDRAW
  } state_e;

  typedef enum logic [1:0] {
    C_ABORT = 2'b00,
    C_CRC   = 2'b01,
    C_PRERR = 2'b10,
    C_TMO   = 2'b11
  } cause_e;
endpackage

// File: rtl/pr_sync.sv
module pr_sync #(
  parameter int W      = 4,
  parameter int STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  for (genvar b = 0; b < W; b++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain_q <= '0;
      else         chain_q <= {chain_q[STAGES-2:0], d_i[b]};
    end
    assign q_o[b] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/pr_gap_timer.sv
module pr_gap_timer #(
  parameter int GAP = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  output logic gap_ok_o
);
  localparam int CW = $clog2(GAP + 1);
  localparam logic [CW-1:0] GapVal = CW'(GAP);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= GapVal;
    else if (req_i)           cnt_q <= '0;
    else if (cnt_q != GapVal) cnt_q <= cnt_q + 1'b1;
  end

  assign gap_ok_o = (cnt_q == GapVal);
endmodule

// File: rtl/pr_wait_timer.sv
module pr_wait_timer #(
  parameter int TW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          clr_i,
  input  logic [TW-1:0] lim_i,
  output logic          hit_o
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_q <= '0;
    else if (clr_i)                  cnt_q <= '0;
    else if (en_i && cnt_q != '1)    cnt_q <= cnt_q + 1'b1;
  end

  assign hit_o = en_i && (lim_i != '0) && (cnt_q >= lim_i);
endmodule

// File: rtl/pr_host_seq.sv
module pr_host_seq
  import pr_seq_pkg::*;
#(
  parameter int DW  = 16,
  parameter int TW  = 16,
  parameter int GAP = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic          abort_i,
  input  logic [TW-1:0] timeout_lim_i,
  input  logic [DW-1:0] src_data_i,
  input  logic          src_valid_i,
  input  logic          src_last_i,
  output logic          src_ready_o,
  output logic          ctl_req_o,
  output logic [DW-1:0] ctl_data_o,
  output logic          ctl_data_vld_o,
  input  logic          ctl_ready_i,
  input  logic          ctl_done_i,
  input  logic          ctl_err_i,
  input  logic          ctl_crc_err_i,
  output logic          busy_o,
  output logic          ok_o,
  output logic          fail_o,
  output logic [1:0]    fail_cause_o
);
  localparam int NSYNC = 4;

  state_e state_q, state_d;
  logic [NSYNC-1:0] async_in, async_s;
  logic rdy_s, done_s, err_s, crc_s;
  logic gap_ok, tmo_hit, tmo_en;
  logic ok_d, fail_d;
  cause_e cause_d;
  logic in_session, take;
  logic req_q;

  assign async_in = {ctl_crc_err_i, ctl_err_i, ctl_done_i, ctl_ready_i};

  pr_sync #(.W(NSYNC), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (async_in),
    .q_o   (async_s)
  );

  assign {crc_s, err_s, done_s, rdy_s} = async_s;

  pr_gap_timer #(.GAP(GAP)) u_gap (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .req_i   (req_q),
    .gap_ok_o(gap_ok)
  );

  assign tmo_en = (state_q == S_REQ) || (state_q == S_FLUSH);

  pr_wait_timer #(.TW(TW)) u_tmo (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (tmo_en),
    .clr_i (state_d != state_q),
    .lim_i (timeout_lim_i),
    .hit_o (tmo_hit)
  );

  assign in_session = (state_q == S_REQ) || (state_q == S_STREAM) || (state_q == S_FLUSH);
  assign src_ready_o = (state_q == S_STREAM);
  assign take = src_ready_o && src_valid_i;

  // priority: controller error > timeout > abort > progress
  always_comb begin
    state_d = state_q;
    ok_d    = 1'b0;
    fail_d  = 1'b0;
    cause_d = C_ABORT;
    unique case (state_q)
      S_IDLE: if (start_i && gap_ok) state_d = S_REQ;
      S_REQ, S_STREAM, S_FLUSH: begin
        if (crc_s || err_s) begin
          fail_d  = 1'b1;
          cause_d = crc_s ? C_CRC : C_PRERR;
          state_d = S_ERR_HOLD;
        end else if (tmo_hit) begin
          fail_d  = 1'b1;
          cause_d = C_TMO;
          state_d = S_WITHDRAW;
        end else if (abort_i) begin
          fail_d  = 1'b1;
          cause_d = C_ABORT;
          state_d = S_WITHDRAW;
        end else begin
          unique case (state_q)
            S_REQ:    if (rdy_s) state_d = S_STREAM;
            S_STREAM: if (take && src_last_i) state_d = S_FLUSH;
            default: if (done_s) begin
              ok_d    = 1'b1;
              state_d = S_DONE_WAIT;
            end
          endcase
        end
      end
      S_DONE_WAIT: if (!done_s) state_d = S_IDLE;
      S_ERR_HOLD:  if (!rdy_s) state_d = S_ERR_CLR;
      S_ERR_CLR:   if (!err_s && !crc_s) state_d = S_IDLE;
      S_WITHDRAW:  if (!rdy_s) state_d = S_IDLE;
      default:     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q        <= S_IDLE;
      req_q          <= 1'b0;
      ok_o           <= 1'b0;
      fail_o         <= 1'b0;
      fail_cause_o   <= 2'b00;
      ctl_data_o     <= '0;
      ctl_data_vld_o <= 1'b0;
    end else begin
      state_q        <= state_d;
      req_q          <= (state_d == S_REQ) || (state_d == S_STREAM) ||
                        (state_d == S_FLUSH) || (state_d == S_ERR_HOLD);
      ok_o           <= ok_d;
      fail_o         <= fail_d;
      fail_cause_o   <= fail_d ? cause_d : 2'b00;
      ctl_data_o     <= take ? src_data_i : '0;
      ctl_data_vld_o <= take;
    end
  end

  assign ctl_req_o = req_q;
  assign busy_o    = (state_q != S_IDLE);

  logic unused_in_session;
  assign unused_in_session = in_session;
endmodule

// File: rtl/pr_host_seq_chk.sv
module pr_host_seq_chk #(
  parameter int DW  = 16,
  parameter int GAP = 10
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          src_ready_o,
  input logic          ctl_req_o,
  input logic [DW-1:0] ctl_data_o,
  input logic          ctl_data_vld_o,
  input logic          busy_o,
  input logic          ok_o,
  input logic          fail_o
);
  localparam int LW = $clog2(GAP + 2);
  localparam logic [LW-1:0] Sat = LW'(GAP);

  logic [LW-1:0] low_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               low_cnt_q <= Sat;
    else if (ctl_req_o)        low_cnt_q <= '0;
    else if (low_cnt_q != Sat) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assert_bus_zero_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctl_data_vld_o |-> ctl_data_o == '0);

  assert_src_needs_req_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    src_ready_o |-> ctl_req_o);

  assert_ok_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |=> !ok_o);

  assert_ok_drops_req_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ok_o |-> !ctl_req_o);

  assert_fail_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fail_o |=> !fail_o);

  assert_no_dual_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ok_o && fail_o));

  assert_gap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctl_req_o) |-> low_cnt_q >= Sat);

  assert_busy_cover_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!ctl_req_o && !src_ready_o));
endmodule

bind pr_host_seq pr_host_seq_chk #(.DW(DW), .GAP(GAP)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .src_ready_o   (src_ready_o),
  .ctl_req_o     (ctl_req_o),
  .ctl_data_o    (ctl_data_o),
  .ctl_data_vld_o(ctl_data_vld_o),
  .busy_o        (busy_o),
  .ok_o          (ok_o),
  .fail_o        (fail_o)
);

// File: tb/pr_host_seq_tb.sv
module pr_host_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int DW  = 16;
  localparam int TW  = 16;
  localparam int GAP = 10;
  localparam int EV_OK = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          start_i = 1'b0, abort_i = 1'b0;
  logic [TW-1:0] timeout_lim_i = 16'd200;
  logic [DW-1:0] src_data_i = '0;
  logic          src_valid_i = 1'b0, src_last_i = 1'b0;
  logic          src_ready_o, ctl_req_o, ctl_data_vld_o;
  logic [DW-1:0] ctl_data_o;
  logic          ctl_ready_i = 1'b0, ctl_done_i = 1'b0, ctl_err_i = 1'b0, ctl_crc_err_i = 1'b0;
  logic          busy_o, ok_o, fail_o;
  logic [1:0]    fail_cause_o;

  int checks = 0, fails = 0;
  logic [DW-1:0] word_q[$];
  int            evt_q[$];
  int            low_run = 0;
  bit            seen_rise = 1'b0;
  logic          req_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pr_host_seq #(.DW(DW), .TW(TW), .GAP(GAP)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .start_i(start_i), .abort_i(abort_i),
    .timeout_lim_i(timeout_lim_i), .src_data_i(src_data_i), .src_valid_i(src_valid_i),
    .src_last_i(src_last_i), .src_ready_o(src_ready_o), .ctl_req_o(ctl_req_o),
    .ctl_data_o(ctl_data_o), .ctl_data_vld_o(ctl_data_vld_o), .ctl_ready_i(ctl_ready_i),
    .ctl_done_i(ctl_done_i), .ctl_err_i(ctl_err_i), .ctl_crc_err_i(ctl_crc_err_i),
    .busy_o(busy_o), .ok_o(ok_o), .fail_o(fail_o), .fail_cause_o(fail_cause_o)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
    end
  endtask

  // monitor: data words, events, bus idle value, request gap
  always @(negedge clk) begin
    if (rst_ni) begin
      if (ctl_data_vld_o) begin
        if (word_q.size() == 0) chk(1'b0, "R3 unexpected word", int'(ctl_data_o), -1);
        else begin
          logic [DW-1:0] e;
          e = word_q.pop_front();
          chk(ctl_data_o == e, "R3 word", int'(ctl_data_o), int'(e));
        end
      end else if (ctl_data_o != '0) chk(1'b0, "R4 bus not zero", int'(ctl_data_o), 0);
      if (ok_o && fail_o) chk(1'b0, "R11 ok and fail together", 1, 0);
      if (ok_o || fail_o) begin
        int got;
        got = ok_o ? EV_OK : int'(fail_cause_o);
        if (evt_q.size() == 0) chk(1'b0, "R5-R9 unexpected event", got, -1);
        else begin
          int e;
          e = evt_q.pop_front();
          chk(got == e, "R5/R6/R7/R8/R9/R11 event", got, e);
        end
      end
      if (ctl_req_o && !req_prev) begin
        if (seen_rise) chk(low_run >= GAP, "R10 request gap", low_run, GAP);
        seen_rise = 1'b1;
      end
      low_run  = ctl_req_o ? 0 : low_run + 1;
      req_prev = ctl_req_o;
    end
  end

  task automatic wait_req(input logic lvl);
    for (int k = 0; k < 400 && ctl_req_o != lvl; k++) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && busy_o; k++) @(negedge clk);
    chk(busy_o == 1'b0, "R12 busy falls", int'(busy_o), 0);
  endtask

  task automatic begin_session();
    @(negedge clk);
    start_i = 1'b1;
    wait_req(1'b1);
    start_i = 1'b0;
    chk(ctl_req_o == 1'b1, "R2 request raised", int'(ctl_req_o), 1);
    chk(busy_o == 1'b1, "R12 busy during session", int'(busy_o), 1);
  endtask

  task automatic send_words(input int n, input int base, input int stall_every);
    for (int i = 0; i < n; i++) begin
      if (stall_every != 0 && i % stall_every == 1) begin
        @(negedge clk);
        src_valid_i = 1'b0;
      end
      @(negedge clk);
      src_valid_i = 1'b1;
      src_data_i  = DW'(base + i * 37);
      src_last_i  = (i == n - 1);
      while (!src_ready_o) @(negedge clk);
      word_q.push_back(src_data_i);
    end
    @(negedge clk);
    src_valid_i = 1'b0;
    src_last_i  = 1'b0;
    src_data_i  = '0;
  endtask

  task automatic good_session(input int n, input int base, input int stall_every);
    begin_session();
    repeat (3) @(negedge clk);
    chk(src_ready_o == 1'b0, "R2 no source accept before ready", int'(src_ready_o), 0);
    chk(ctl_data_o == '0, "R2 bus zero while requesting", int'(ctl_data_o), 0);
    ctl_ready_i = 1'b1;
    evt_q.push_back(EV_OK);
    send_words(n, base, stall_every);
    repeat (4) @(negedge clk);
    chk(src_ready_o == 1'b0, "R3 streaming ends at last word", int'(src_ready_o), 0);
    ctl_done_i  = 1'b1;
    ctl_ready_i = 1'b0;
    wait_req(1'b0);
    chk(ctl_req_o == 1'b0, "R5 request withdrawn after done", int'(ctl_req_o), 0);
    chk(busy_o == 1'b1, "R5 busy until done clears", int'(busy_o), 1);
    repeat (3) @(negedge clk);
    ctl_done_i = 1'b0;
    wait_idle();
  endtask

  task automatic error_session(input bit crc, input int exp_cause);
    begin_session();
    repeat (2) @(negedge clk);
    ctl_ready_i = 1'b1;
    repeat (2) @(negedge clk);
    ctl_err_i = 1'b1;
    ctl_crc_err_i = crc;
    evt_q.push_back(exp_cause);
    repeat (8) @(negedge clk);
    chk(ctl_req_o == 1'b1, crc ? "R7 request held while ready" : "R6 request held while ready",
        int'(ctl_req_o), 1);
    ctl_ready_i = 1'b0;
    wait_req(1'b0);
    chk(ctl_req_o == 1'b0, crc ? "R7 request withdrawn" : "R6 request withdrawn", int'(ctl_req_o), 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b1, "R6 busy until error clears", int'(busy_o), 1);
    ctl_err_i = 1'b0;
    ctl_crc_err_i = 1'b0;
    wait_idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(ctl_req_o == 1'b0 && busy_o == 1'b0 && ok_o == 1'b0 && fail_o == 1'b0,
        "R1 reset outputs", int'({ctl_req_o, busy_o, ok_o, fail_o}), 0);
    chk(ctl_data_o == '0 && ctl_data_vld_o == 1'b0 && src_ready_o == 1'b0,
        "R1 reset data", int'(ctl_data_o), 0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);

    good_session(6, 16'h1200, 0);      // R3 dense stream
    good_session(9, 16'h0a05, 3);      // R3 stalled stream, back-to-back for R10
    error_session(1'b0, 2);            // R6 PR error
    error_session(1'b1, 1);            // R7 CRC with PR error together

    // R8 timeout waiting for ready
    timeout_lim_i = 16'd40;
    begin_session();
    evt_q.push_back(3);
    wait_req(1'b0);
    chk(ctl_req_o == 1'b0, "R8 request dropped on timeout", int'(ctl_req_o), 0);
    wait_idle();

    // R8 timeout waiting for done
    begin_session();
    repeat (2) @(negedge clk);
    ctl_ready_i = 1'b1;
    send_words(3, 16'h0300, 0);
    evt_q.push_back(3);
    wait_req(1'b0);
    chk(ctl_req_o == 1'b0, "R8 done timeout drops request", int'(ctl_req_o), 0);
    chk(busy_o == 1'b1, "R8 busy while ready high", int'(busy_o), 1);
    ctl_ready_i = 1'b0;
    wait_idle();
    timeout_lim_i = 16'd200;

    // R9 abort before ready
    begin_session();
    repeat (2) @(negedge clk);
    abort_i = 1'b1;
    evt_q.push_back(0);
    @(negedge clk);
    abort_i = 1'b0;
    @(negedge clk);
    chk(ctl_req_o == 1'b0, "R9 early abort withdraws", int'(ctl_req_o), 0);
    wait_idle();

    // R9 abort after ready
    begin_session();
    repeat (2) @(negedge clk);
    ctl_ready_i = 1'b1;
    repeat (6) @(negedge clk);
    abort_i = 1'b1;
    evt_q.push_back(0);
    @(negedge clk);
    abort_i = 1'b0;
    @(negedge clk);
    chk(ctl_req_o == 1'b0, "R9 late abort withdraws", int'(ctl_req_o), 0);
    repeat (3) @(negedge clk);
    chk(busy_o == 1'b1, "R9 busy until ready low", int'(busy_o), 1);
    ctl_ready_i = 1'b0;
    wait_idle();

    // R11 done and PR error in the same cycle
    begin_session();
    repeat (2) @(negedge clk);
    ctl_ready_i = 1'b1;
    send_words(4, 16'h7700, 2);
    repeat (3) @(negedge clk);
    ctl_done_i = 1'b1;
    ctl_err_i  = 1'b1;
    evt_q.push_back(2);
    repeat (6) @(negedge clk);
    chk(ctl_req_o == 1'b1, "R11 error path holds request", int'(ctl_req_o), 1);
    ctl_ready_i = 1'b0;
    wait_req(1'b0);
    ctl_done_i = 1'b0;
    ctl_err_i  = 1'b0;
    wait_idle();

    good_session(5, 16'h4000, 2);      // recovery after errors

    repeat (20) @(negedge clk);
    chk(word_q.size() == 0, "R3 all words delivered", word_q.size(), 0);
    chk(evt_q.size() == 0, "R5 all events reported", evt_q.size(), 0);
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule